// File: doc/BRIEF.md
# Register-Pointer I2C Slave

This block is an I2C-compatible slave that lets a host reach a small bank of internal byte registers through an auto-incrementing register pointer. It runs entirely on the system clock. SCL and SDA are brought in through synchronizers and edge detectors. Start, repeated-start and stop conditions are recognised at any point in a transfer. The slave answers only to its fixed 7-bit device address.

In a write transaction, the first byte after the address byte sets the pointer. Each following byte is offered to the register bank as a one-cycle write strobe at the pointer's address, and the pointer then steps forward. In a read transaction, bytes are taken from the bank's combinational read port at the current pointer. Each byte the master acknowledges moves the pointer on by one.

A stop always returns the pointer to address 0x00, so the status register can be polled without rewriting the pointer. At the start of each read burst a single-cycle snapshot request goes to the bank. The bank uses it to freeze its multi-byte results, so one burst never mixes two conversions.

Top module: `i2c_ptr_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) and a stop (SDA rising while SCL is high) are recognised at any point, including in the middle of a byte. A stop in the middle of a data byte produces no register write.
- R2: After a start, the slave shifts in 8 bits MSB first: a 7-bit address, then R/W (0 = write, 1 = read). For device address 0x48 (bytes 0x90 and 0x91) it pulls SDA low during the ninth clock.
- R3: For any other address the slave does not acknowledge. It then ignores all traffic until the next start and issues no register write.
- R4: In a write transaction, the first byte after the address byte is loaded into the pointer and acknowledged.
- R5: Each further write byte is acknowledged and produces exactly one one-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments by one.
- R6: A write byte at a pointer above 0x12 produces no `reg_we` pulse, but it is still acknowledged and the pointer still increments.
- R7: In a read transaction, the byte at the pointer is sent MSB first. If the master acknowledges, the pointer increments and the next byte follows. If the master does not acknowledge, the slave goes idle with the pointer unchanged, so a repeated-start read returns the same register.
- R8: A read keeps streaming past address 0x12 until NACK, start or stop. Every byte read at a pointer above 0x12 is 0x00, whatever the bank presents.
- R9: Any stop sets the pointer (`reg_addr`) to 0x00.
- R10: `snap_o` pulses for exactly one cycle, once per read transaction, after the read address byte is accepted. It does not pulse in a write transaction.
- R11: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R12: After reset, `sda_oe`, `reg_we` and `snap_o` are 0 and `reg_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 8 | Register pointer, used as the write and read address |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_rdata | input | 8 | Combinational read data of the register at `reg_addr` |
| snap_o | output | 1 | One-cycle request to freeze result registers for a read burst |

## Verification
The bench drives a bit-level master against a behavioural register bank. Above 0x12 that bank returns 0xEE, so a design that forwarded out-of-range read data instead of 0x00 is caught at once. A NACK followed by a repeated-start read must return the same register; a design that bumped the pointer on NACK would return the next one. A write at pointer 0x12 continues to 0x13, exposing a slave that stores or fails to acknowledge out-of-range bytes. A stop in the middle of a byte followed by a fresh read of address 0x00 exposes a slave that keeps a half-received byte or forgets to clear the pointer. A wrong device address followed by data shows whether the slave stays off the bus until the next start.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  // Idle bus is high: all stages reset to 1 so no edge is seen at release.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o     = scl_pipe[STAGES-1];
  assign sda_o     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_o & ~scl_d;
  assign scl_fall  = ~scl_o & scl_d;
  assign start_det = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_det  = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/i2c_bit_shift.sv
module i2c_bit_shift #(
  parameter int unsigned W = 8
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       clr,
  input  logic                       rise,
  input  logic                       din,
  output logic [W-1:0]               byte_o,
  output logic [$clog2(W+1)-1:0]     cnt_o,
  output logic                       full_o
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  // The count saturates at W so the byte stays stable through the ack bit.
  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    en    = 1'b0;
    if (clr) begin
      cnt_d = '0;
      en    = 1'b1;
    end else if (rise && (cnt_q != CW'(W))) begin
      sh_d  = {sh_q[W-2:0], din};
      cnt_d = cnt_q + 1'b1;
      en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign byte_o = sh_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(W));

endmodule

// File: rtl/i2c_ptr_reg.sv
module i2c_ptr_reg #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr,
  input  logic          ld,
  input  logic          inc,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          en;

  // Priority: clear (stop) over load (pointer byte) over increment.
  always_comb begin
    en    = clr | ld | inc;
    ptr_d = ptr_q;
    if (clr)      ptr_d = '0;
    else if (ld)  ptr_d = din;
    else if (inc) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  ptr_q <= '0;
    else if (en)  ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h48,
  parameter int unsigned       AW          = 8,
  parameter logic [AW-1:0]     REG_LAST    = 8'h12,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata,
  output logic          snap_o
);

  localparam int unsigned DW = BYTE_W;
  localparam int unsigned CW = $clog2(DW + 1);

  // Reset: asynchronous assertion, synchronous release.
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic          cnt_clr;
  logic [DW-1:0] rx_byte;
  logic [CW-1:0] bit_cnt;
  logic          byte_full;

  i2c_bit_shift #(.W(DW)) u_shift (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr    (cnt_clr),
    .rise   (scl_rise),
    .din    (sda_s),
    .byte_o (rx_byte),
    .cnt_o  (bit_cnt),
    .full_o (byte_full)
  );

  logic          ptr_clr, ptr_ld, ptr_inc;
  logic [AW-1:0] ptr;

  i2c_ptr_reg #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr    (ptr_clr),
    .ld     (ptr_ld),
    .inc    (ptr_inc),
    .din    (rx_byte[AW-1:0]),
    .ptr_o  (ptr)
  );

  slv_state_e    st_q, st_d;
  logic          oe_q, oe_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic          we_q, we_d;
  logic [DW-1:0] wdata_q;
  logic          snap_q, snap_d;

  logic          ptr_ok;
  logic [DW-1:0] rd_byte;

  assign ptr_ok  = (ptr <= REG_LAST);
  assign rd_byte = ptr_ok ? reg_rdata : '0;

  always_comb begin
    st_d    = st_q;
    oe_d    = oe_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    we_d    = 1'b0;
    snap_d  = 1'b0;
    cnt_clr = 1'b0;
    ptr_clr = 1'b0;
    ptr_ld  = 1'b0;
    ptr_inc = 1'b0;
    if (stop_det) begin
      st_d    = ST_IDLE;
      oe_d    = 1'b0;
      ptr_clr = 1'b1;
    end else if (start_det) begin
      st_d    = ST_ADDR;
      oe_d    = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_fall && byte_full) begin
            if (rx_byte[DW-1:1] == DEV_ADDR) begin
              st_d   = ST_ADDR_ACK;
              oe_d   = 1'b1;
              rw_d   = rx_byte[0];
              snap_d = rx_byte[0];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_clr = 1'b1;
            if (rw_q) begin
              st_d = ST_RDATA;
              tx_d = rd_byte;
              oe_d = ~rd_byte[DW-1];
            end else begin
              st_d = ST_PTR;
              oe_d = 1'b0;
            end
          end
        end
        ST_PTR: begin
          if (scl_fall && byte_full) begin
            ptr_ld = 1'b1;
            st_d   = ST_PTR_ACK;
            oe_d   = 1'b1;
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall) begin
            st_d    = ST_WDATA;
            oe_d    = 1'b0;
            cnt_clr = 1'b1;
          end
        end
        ST_WDATA: begin
          if (scl_fall && byte_full) begin
            we_d = ptr_ok;
            st_d = ST_WDATA_ACK;
            oe_d = 1'b1;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            ptr_inc = 1'b1;
            st_d    = ST_WDATA;
            oe_d    = 1'b0;
            cnt_clr = 1'b1;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (byte_full) begin
              st_d = ST_RDATA_ACK;
              oe_d = 1'b0;
            end else if (bit_cnt != '0) begin
              tx_d = {tx_q[DW-2:0], 1'b0};
              oe_d = ~tx_q[DW-2];
            end
          end
        end
        ST_RDATA_ACK: begin
          // Pointer steps on the acknowledge rise so read data has settled by the fall.
          if (scl_rise) begin
            mack_d  = ~sda_s;
            ptr_inc = ~sda_s;
          end
          if (scl_fall) begin
            if (mack_q) begin
              st_d    = ST_RDATA;
              cnt_clr = 1'b1;
              tx_d    = rd_byte;
              oe_d    = ~rd_byte[DW-1];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      oe_q   <= 1'b0;
      tx_q   <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      we_q   <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      oe_q   <= oe_d;
      tx_q   <= tx_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      we_q   <= we_d;
      snap_q <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   wdata_q <= '0;
    else if (we_d) wdata_q <= rx_byte;
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign snap_o    = snap_q;

endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk #(
  parameter int unsigned   AW       = 8,
  parameter logic [AW-1:0] REG_LAST = 8'h12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          snap_o,
  input logic          stop_det,
  input logic          start_det,
  input logic          ptr_ld
);

  // R11: the drive enable moves only while SCL is low (bus-condition aborts excepted)
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe != $past(sda_oe)) && !$past(stop_det) && !$past(start_det)) |-> !scl_i);

  // R9: a stop clears the pointer
  assert_stop_clears_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (reg_addr == '0));

  // R6: no strobe for pointers beyond the last valid register
  assert_we_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr <= REG_LAST));

  // R5: one strobe per data byte
  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5/R7: pointer moves by one, to zero, or by an explicit load
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != $past(reg_addr)) |->
      ((reg_addr == $past(reg_addr) + 1'b1) || (reg_addr == '0) || $past(ptr_ld)));

  // R10: snapshot request is a single-cycle pulse
  assert_snap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snap_o |=> !snap_o);

endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk #(.AW(AW), .REG_LAST(REG_LAST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .snap_o    (snap_o),
  .stop_det  (stop_det),
  .start_det (start_det),
  .ptr_ld    (ptr_ld)
);

// File: tb/i2c_ptr_slave_tb_top.sv
module i2c_ptr_slave_tb_top;

  localparam int QTR  = 10;
  localparam int LAST = 18;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       sda_line;
  logic       sda_oe;
  logic       reg_we;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       snap_o;

  logic [7:0] mem [0:LAST];
  int         wr_cnt;
  int         snap_cnt;
  int         n_cmp;
  int         n_bad;
  logic       oe_prev;
  logic       scl_at_edge;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_ptr_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .snap_o    (snap_o)
  );

  // Behavioural register bank; 0xEE above the valid range.
  always_comb reg_rdata = (reg_addr <= 8'(LAST)) ? mem[reg_addr[4:0]] : 8'hEE;

  always @(posedge clk) begin
    scl_at_edge <= scl_m;
    if (reg_we && reg_addr <= 8'(LAST)) mem[reg_addr[4:0]] <= reg_wdata;
    if (reg_we) wr_cnt <= wr_cnt + 1;
    if (snap_o) snap_cnt <= snap_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R11 monitor: drive enable may change only across a clock edge where SCL was low.
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev)) chk("R11 sda_oe changed with SCL high", 32'(scl_at_edge), 0);
    oe_prev = sda_oe;
  end

  task automatic q_wait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic put_bit(input logic v);
    sda_m = v; q_wait();
    scl_m = 1'b1; q_wait(); q_wait();
    scl_m = 1'b0; q_wait();
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; q_wait();
    scl_m = 1'b1; q_wait();
    v = sda_line; q_wait();
    scl_m = 1'b0; q_wait();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait();
    scl_m = 1'b1; q_wait();
    sda_m = 1'b0; q_wait();
    scl_m = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait();
    scl_m = 1'b1; q_wait();
    sda_m = 1'b1; q_wait(); q_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(v);
    ack = ~v;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~mack);
  endtask

  task automatic t_reset();
    chk("R12 reset sda_oe", 32'(sda_oe), 0);
    chk("R12 reset reg_we", 32'(reg_we), 0);
    chk("R12 reset snap_o", 32'(snap_o), 0);
    chk("R12 reset reg_addr", 32'(reg_addr), 0);
  endtask

  task automatic t_wrong_addr();
    logic ack; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h94, ack);
    chk("R3 foreign address not acked", 32'(ack), 0);
    send_byte(8'h05, ack);
    chk("R3 later byte ignored", 32'(ack), 0);
    send_byte(8'h77, ack);
    chk("R3 data byte ignored", 32'(ack), 0);
    bus_stop();
    chk("R3 no write strobe", 32'(wr_cnt - w0), 0);
  endtask

  task automatic t_write_burst();
    logic ack; int w0, s0;
    w0 = wr_cnt; s0 = snap_cnt;
    bus_start();
    send_byte(8'h90, ack);
    chk("R2 write address acked", 32'(ack), 1);
    send_byte(8'h05, ack);
    chk("R4 pointer byte acked", 32'(ack), 1);
    chk("R4 pointer loaded", 32'(reg_addr), 32'h05);
    send_byte(8'hA1, ack); chk("R5 data ack 0", 32'(ack), 1);
    send_byte(8'hB2, ack); chk("R5 data ack 1", 32'(ack), 1);
    send_byte(8'hC3, ack); chk("R5 data ack 2", 32'(ack), 1);
    chk("R5 pointer advanced", 32'(reg_addr), 32'h08);
    bus_stop();
    chk("R5 reg 5", 32'(mem[5]), 32'hA1);
    chk("R5 reg 6", 32'(mem[6]), 32'hB2);
    chk("R5 reg 7", 32'(mem[7]), 32'hC3);
    chk("R5 strobe count", 32'(wr_cnt - w0), 3);
    chk("R9 pointer cleared by stop", 32'(reg_addr), 0);
    chk("R10 no snapshot on write", 32'(snap_cnt - s0), 0);
  endtask

  task automatic t_poll_status();
    logic ack; logic [7:0] b; int s0;
    s0 = snap_cnt;
    bus_start();
    send_byte(8'h91, ack);
    chk("R2 read address acked", 32'(ack), 1);
    recv_byte(1'b0, b);
    chk("R9 read after stop gives status", 32'(b), 32'h40);
    bus_stop();
    chk("R10 one snapshot per read", 32'(snap_cnt - s0), 1);
  endtask

  task automatic t_invalid_write();
    logic ack; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h90, ack);
    send_byte(8'h12, ack);
    send_byte(8'h5A, ack); chk("R6 last valid acked", 32'(ack), 1);
    send_byte(8'h6B, ack); chk("R6 out-of-range acked", 32'(ack), 1);
    chk("R6 pointer still advanced", 32'(reg_addr), 32'h14);
    bus_stop();
    chk("R6 only one strobe", 32'(wr_cnt - w0), 1);
    chk("R6 reg 0x12 written", 32'(mem[18]), 32'h5A);
  endtask

  task automatic t_read_stream();
    logic ack; logic [7:0] b; int s0;
    s0 = snap_cnt;
    bus_start();
    send_byte(8'h90, ack);
    send_byte(8'h10, ack);
    bus_start();
    send_byte(8'h91, ack);
    chk("R1 repeated start read acked", 32'(ack), 1);
    recv_byte(1'b1, b); chk("R7 byte at 0x10", 32'(b), 32'h50);
    recv_byte(1'b1, b); chk("R7 byte at 0x11", 32'(b), 32'h51);
    recv_byte(1'b1, b); chk("R7 byte at 0x12", 32'(b), 32'h5A);
    recv_byte(1'b1, b); chk("R8 byte at 0x13 is zero", 32'(b), 0);
    recv_byte(1'b0, b); chk("R8 byte at 0x14 is zero", 32'(b), 0);
    bus_stop();
    chk("R10 one snapshot for burst", 32'(snap_cnt - s0), 1);
  endtask

  task automatic t_nack_hold();
    logic ack; logic [7:0] b;
    bus_start();
    send_byte(8'h90, ack);
    send_byte(8'h03, ack);
    bus_start();
    send_byte(8'h91, ack);
    recv_byte(1'b0, b); chk("R7 first read at 0x03", 32'(b), 32'h43);
    chk("R7 NACK keeps pointer", 32'(reg_addr), 32'h03);
    bus_start();
    send_byte(8'h91, ack);
    recv_byte(1'b0, b); chk("R7 reread after NACK", 32'(b), 32'h43);
    bus_stop();
  endtask

  task automatic t_stop_abort();
    logic ack; logic [7:0] b; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte(8'h90, ack);
    send_byte(8'h08, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop();
    chk("R1 no write from half byte", 32'(wr_cnt - w0), 0);
    chk("R9 pointer cleared mid-byte", 32'(reg_addr), 0);
    bus_start();
    send_byte(8'h91, ack);
    chk("R1 new transaction after abort", 32'(ack), 1);
    recv_byte(1'b0, b);
    chk("R9 status after abort", 32'(b), 32'h40);
    bus_stop();
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; wr_cnt = 0; snap_cnt = 0;
    oe_prev = 1'b0;
    for (int i = 0; i <= LAST; i++) mem[i] = 8'(8'h40 + i);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wrong_addr();
    t_write_burst();
    t_poll_status();
    t_invalid_write();
    t_read_stream();
    t_nack_hold();
    t_stop_abort();
    repeat (20) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule